// File: doc/BRIEF.md
# Reset and Hardware Power-Down Controller

This block turns two active-low pins into the chip's reset and deep-sleep control. The reset pin and the power-down pin are sampled on the oscillator clock and timed in machine cycles of `OSC_PER_MC` clocks. A short low on either pin does nothing. A low lasting one machine cycle resets the core. A low on the power-down pin that lasts beyond `PD_MC` machine cycles puts the part into hardware power-down, where every pad is told to float. Reset requests from the watchdog timer and the oscillator watchdog join the same path. Every reset is stretched to a minimum length and is also driven onto a reset-output pin.

When reset is released, the block captures two configuration pins. The program-enable pin becomes the bootstrap-request flag, and the power-save-enable pin becomes the watchdog auto-start flag. The power-save-enable pin also gates the software requests for the three power-saving modes while the core runs. The controller is a four-state machine:

- `ST_RESET` holds the core in reset and counts the stretch.
- `ST_PWRDN` floats the pins.
- `ST_RELEASE` is the single cycle in which the configuration is captured.
- `ST_RUN` is normal operation.

The transitions are:

- `ST_RUN` to `ST_RESET` on any qualified request.
- `ST_RESET` to `ST_PWRDN` when the power-down low passes its limit.
- `ST_RESET` to `ST_RELEASE` when the stretch is done and every source is quiet.
- `ST_PWRDN` to `ST_RESET` when the power-down pin goes high again.
- `ST_RELEASE` to `ST_RUN` always.
- Power-on reset (`por_n` low) forces `ST_RESET`.

Every pin passes through a `SYNC_STAGES` flop synchronizer before it is timed. With the defaults (6 clocks per machine cycle, two synchronizer flops), a pin low held for L clock edges gives a low count of exactly L.

Top module: `rpd_ctrl`

## Requirements
- R1: A low on `rst_pin_n` held for fewer than 6 clocks leaves `cpu_reset` at 0. A low held for 6 clocks or more raises `cpu_reset`, and the core runs again after the pin returns high.
- R2: A low on `hpd_pin_n` held for 6 to 12 clocks resets the core and never raises `pins_float`. A low shorter than 6 clocks has no effect.
- R3: A low on `hpd_pin_n` held for 13 clocks or more raises `pins_float` with `cpu_reset` high. When the pin returns high, a full reset follows and the core then runs with `pins_float` at 0.
- R4: A single-cycle pulse on `wdt_rst_req` or on `owdt_rst_req` while running holds `cpu_reset` and `reset_out` high for exactly 7 clocks (the 6-clock stretch plus the release cycle).
- R5: `reset_out` is 1 in `ST_RESET` and `ST_RELEASE`, and it is 0 while `pins_float` is 1.
- R6: `boot_mode` takes the value of `prog_pin` (1 = bootstrap requested) at the release of each reset, including a reset that follows power-down. Changes on the pin while running do not affect it.
- R7: `wdt_autostart` takes the value of `psen_pin` at the release of each reset (1 = watchdog starts at once, 0 = watchdog off).
- R8: While running, `save_grant` equals `sw_save_req` when the synchronized `psen_pin` is 0, and is all zero when it is 1. Bit 0 is idle, bit 1 is slow-down, bit 2 is power-down.
- R9: While `por_n` is low, `cpu_reset` and `reset_out` are 1, and `pins_float`, `boot_mode` and `wdt_autostart` are 0. After `por_n` rises with all pins high, the core runs.
- R10: Power-down entry takes precedence over watchdog requests that arrive in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset of the controller, active low |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| hpd_pin_n | input | 1 | Hardware power-down pin, active low, asynchronous |
| prog_pin | input | 1 | Program-enable configuration pin |
| psen_pin | input | 1 | Power-save-enable pin |
| wdt_rst_req | input | 1 | Reset request from the watchdog timer, synchronous |
| owdt_rst_req | input | 1 | Reset request from the oscillator watchdog, synchronous |
| sw_save_req | input | 3 | Software requests: idle, slow-down, power-down |
| cpu_reset | output | 1 | Internal reset to the core, active high |
| reset_out | output | 1 | Reset-output pin value, active high |
| pins_float | output | 1 | Float all pads (hardware power-down) |
| boot_mode | output | 1 | Bootstrap requested, captured at release |
| wdt_autostart | output | 1 | Start watchdog after reset, captured at release |
| save_grant | output | 3 | Granted power-saving requests |

## Verification
The power-down threshold and the watchdog reset path can land in the same cycle. Once a long power-down low has pushed the machine into reset, a watchdog request keeps the "stay in reset" condition true in exactly the cycle where the low count reaches its limit. The bench provokes this by toggling `wdt_rst_req` on every clock through a 30-clock low on `hpd_pin_n`. It judges the result by requiring that `pins_float` was seen. It also requires that the core is running again once both the pin and the watchdog are quiet. The 13-clock pulse in the power-down sweep gives a second meeting point: the count reaches its limit in the same cycle the synchronized pin is already back high, so the float lasts one cycle and must still be observed.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_RESET   = 2'd1,
        ST_PWRDN   = 2'd2,
        ST_RELEASE = 2'd3
    } rpd_state_e;

    typedef struct packed {
        logic rst_n;
        logic hpd_n;
        logic prog;
        logic psen;
    } pin_bus_t;

    localparam pin_bus_t PIN_IDLE = '{rst_n: 1'b1, hpd_n: 1'b1, prog: 1'b0, psen: 1'b1};

endpackage

// File: rtl/rpd_sync.sv
module rpd_sync #(
    parameter int unsigned WIDTH     = 4,
    parameter int unsigned STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned NST = (STAGES < 1) ? 1 : STAGES;

    logic [WIDTH-1:0] stage_q [NST];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < NST; i++) stage_q[i] <= RESET_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < NST; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    generate
        if (NST == 1) begin : g_single
            assign q = stage_q[0];
        end else begin : g_chain
            assign q = stage_q[NST-1];
        end
    endgenerate

endmodule

// File: rtl/rpd_low_timer.sv
module rpd_low_timer #(
    parameter int unsigned THR_A = 6,
    parameter int unsigned THR_B = 13
) (
    input  logic clk,
    input  logic por_n,
    input  logic lo,
    output logic hit_a,
    output logic hit_b
);
    localparam int unsigned W = $clog2(THR_B + 1);

    logic [W-1:0] cnt_q;

    // Consecutive low samples, saturating at the upper threshold.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (!lo) begin
            cnt_q <= '0;
        end else if (cnt_q != W'(THR_B)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit_a = (cnt_q >= W'(THR_A));
    assign hit_b = (cnt_q >= W'(THR_B));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q <= W'(THR_B)); // R1

    AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        !lo |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/rpd_fsm.sv
module rpd_fsm
    import rpd_pkg::*;
#(
    parameter int unsigned STRETCH = 6
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_long,
    input  logic       hpd_rst,
    input  logic       hpd_pd,
    input  logic       rst_high,
    input  logic       hpd_high,
    input  logic       wdt_req,
    input  logic       owdt_req,
    input  logic       prog_s,
    input  logic       psen_s,
    input  logic [2:0] sw_req,
    output logic       cpu_reset,
    output logic       reset_out,
    output logic       pins_float,
    output logic       boot_mode,
    output logic       wdt_autostart,
    output logic [2:0] save_grant
);
    localparam int unsigned SW = $clog2(STRETCH + 1);

    rpd_state_e state_q, state_d;
    logic [SW-1:0] st_cnt_q;
    logic          stretch_done;
    logic          any_req;
    logic          all_quiet;
    logic          boot_q, auto_q;

    assign stretch_done = (st_cnt_q >= SW'(STRETCH - 1));
    assign any_req      = rst_long | hpd_rst | wdt_req | owdt_req;
    assign all_quiet    = rst_high & hpd_high & ~wdt_req & ~owdt_req;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (any_req) state_d = ST_RESET;
            end
            ST_RESET: begin
                if (hpd_pd)                          state_d = ST_PWRDN;
                else if (stretch_done && all_quiet)  state_d = ST_RELEASE;
            end
            ST_PWRDN: begin
                if (hpd_high) state_d = ST_RESET;
            end
            ST_RELEASE: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Reset stretch counter, restarted on every entry into ST_RESET
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_cnt_q <= '0;
        end else if (state_q != ST_RESET) begin
            st_cnt_q <= '0;
        end else if (!stretch_done) begin
            st_cnt_q <= st_cnt_q + 1'b1;
        end
    end

    // Configuration capture at the release cycle
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            boot_q <= 1'b0;
            auto_q <= 1'b0;
        end else if (state_q == ST_RELEASE) begin
            boot_q <= prog_s;
            auto_q <= psen_s;
        end
    end

    // Outputs
    always_comb begin
        cpu_reset  = 1'b1;
        reset_out  = 1'b0;
        pins_float = 1'b0;
        save_grant = 3'b000;
        unique case (state_q)
            ST_RUN: begin
                cpu_reset  = 1'b0;
                save_grant = psen_s ? 3'b000 : sw_req;
            end
            ST_RESET: begin
                reset_out = 1'b1;
            end
            ST_PWRDN: begin
                pins_float = 1'b1;
            end
            ST_RELEASE: begin
                reset_out = 1'b1;
            end
        endcase
    end

    assign boot_mode     = boot_q;
    assign wdt_autostart = auto_q;

    AST_FLOAT_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        pins_float |-> cpu_reset); // R3

    AST_RSTOUT_OFF_IN_PD: assert property (@(posedge clk) disable iff (!por_n)
        pins_float |-> !reset_out); // R5

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != ST_RELEASE) |=> ($stable(boot_q) && $stable(auto_q))); // R6

    AST_RELEASE_FROM_RESET: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_RELEASE) |-> ($past(state_q) == ST_RESET)); // R4

    AST_GRANT_RUN_ONLY: assert property (@(posedge clk) disable iff (!por_n)
        (save_grant != 3'b000) |-> !cpu_reset); // R8

endmodule

// File: rtl/rpd_ctrl.sv
module rpd_ctrl
    import rpd_pkg::*;
#(
    parameter int unsigned OSC_PER_MC  = 6,
    parameter int unsigned PD_MC       = 2,
    parameter int unsigned STRETCH_MC  = 1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_pin_n,
    input  logic       hpd_pin_n,
    input  logic       prog_pin,
    input  logic       psen_pin,
    input  logic       wdt_rst_req,
    input  logic       owdt_rst_req,
    input  logic [2:0] sw_save_req,
    output logic       cpu_reset,
    output logic       reset_out,
    output logic       pins_float,
    output logic       boot_mode,
    output logic       wdt_autostart,
    output logic [2:0] save_grant
);
    localparam int unsigned RST_THR = OSC_PER_MC;
    localparam int unsigned PD_THR  = PD_MC * OSC_PER_MC + 1;
    localparam int unsigned STRETCH = STRETCH_MC * OSC_PER_MC;

    pin_bus_t pins_raw, pins_s;
    logic rst_hit_a, rst_hit_b;
    logic hpd_hit_a, hpd_hit_b;

    assign pins_raw = '{rst_n: rst_pin_n, hpd_n: hpd_pin_n, prog: prog_pin, psen: psen_pin};

    rpd_sync #(
        .WIDTH     ($bits(pin_bus_t)),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    rpd_low_timer #(.THR_A(RST_THR), .THR_B(RST_THR)) u_rst_timer (
        .clk   (clk),
        .por_n (por_n),
        .lo    (~pins_s.rst_n),
        .hit_a (rst_hit_a),
        .hit_b (rst_hit_b)
    );

    rpd_low_timer #(.THR_A(RST_THR), .THR_B(PD_THR)) u_hpd_timer (
        .clk   (clk),
        .por_n (por_n),
        .lo    (~pins_s.hpd_n),
        .hit_a (hpd_hit_a),
        .hit_b (hpd_hit_b)
    );

    rpd_fsm #(.STRETCH(STRETCH)) u_fsm (
        .clk           (clk),
        .por_n         (por_n),
        .rst_long      (rst_hit_a),
        .hpd_rst       (hpd_hit_a),
        .hpd_pd        (hpd_hit_b),
        .rst_high      (pins_s.rst_n),
        .hpd_high      (pins_s.hpd_n),
        .wdt_req       (wdt_rst_req),
        .owdt_req      (owdt_rst_req),
        .prog_s        (pins_s.prog),
        .psen_s        (pins_s.psen),
        .sw_req        (sw_save_req),
        .cpu_reset     (cpu_reset),
        .reset_out     (reset_out),
        .pins_float    (pins_float),
        .boot_mode     (boot_mode),
        .wdt_autostart (wdt_autostart),
        .save_grant    (save_grant)
    );

    AST_RESET_HAS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cpu_reset) |-> $past(rst_hit_b || hpd_hit_a || wdt_rst_req || owdt_rst_req)); // R4

    AST_PD_AFTER_LONG_LOW: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pins_float) |-> $past(hpd_hit_b)); // R3

endmodule

// File: tb/sim_rpd_ctrl.sv
module sim_rpd_ctrl;
    localparam int MC = 6;
    localparam int PD_LEN = 2 * MC + 1;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_pin_n = 1'b1, hpd_pin_n = 1'b1, prog_pin = 1'b0, psen_pin = 1'b1;
    logic wdt_rst_req = 1'b0, owdt_rst_req = 1'b0;
    logic [2:0] sw_save_req = 3'b000;
    logic cpu_reset, reset_out, pins_float, boot_mode, wdt_autostart;
    logic [2:0] save_grant;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit mon_on = 1'b0;
    bit saw_rst, saw_flt;
    int ro_cnt;

    rpd_ctrl u0 (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .hpd_pin_n(hpd_pin_n),
        .prog_pin(prog_pin), .psen_pin(psen_pin), .wdt_rst_req(wdt_rst_req),
        .owdt_rst_req(owdt_rst_req), .sw_save_req(sw_save_req),
        .cpu_reset(cpu_reset), .reset_out(reset_out), .pins_float(pins_float),
        .boot_mode(boot_mode), .wdt_autostart(wdt_autostart), .save_grant(save_grant)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (mon_on) begin
            if (cpu_reset) saw_rst = 1'b1;
            if (pins_float) saw_flt = 1'b1;
            if (reset_out) ro_cnt++;
        end
    end

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic arm();
        @(posedge clk);
        saw_rst = 1'b0;
        saw_flt = 1'b0;
        ro_cnt  = 0;
        mon_on  = 1'b1;
    endtask

    task automatic disarm();
        @(posedge clk);
        mon_on = 1'b0;
    endtask

    task automatic pulse_rst(input int len);
        @(negedge clk); rst_pin_n = 1'b0;
        wait_neg(len);
        rst_pin_n = 1'b1;
    endtask

    task automatic pulse_hpd(input int len);
        @(negedge clk); hpd_pin_n = 1'b0;
        wait_neg(len);
        hpd_pin_n = 1'b1;
    endtask

    initial begin
        // R9: power-on state
        wait_neg(4);
        chk(cpu_reset == 1'b1, "R9 cpu_reset in por", int'(cpu_reset), 1);
        chk(reset_out == 1'b1, "R9 reset_out in por", int'(reset_out), 1);
        chk(pins_float == 1'b0, "R9 pins_float in por", int'(pins_float), 0);
        chk(boot_mode == 1'b0 && wdt_autostart == 1'b0, "R9 flags in por",
            int'({boot_mode, wdt_autostart}), 0);
        @(negedge clk); por_n = 1'b1;
        wait_neg(20);
        chk(cpu_reset == 1'b0, "R9 runs after por", int'(cpu_reset), 0);
        chk(wdt_autostart == 1'b1, "R7 autostart after por", int'(wdt_autostart), 1);

        // R1: reset pin length sweep
        for (int len = 1; len <= PD_LEN + 3; len++) begin
            arm();
            pulse_rst(len);
            wait_neg(len + 40);
            disarm();
            chk(saw_rst == (len >= MC), $sformatf("R1 reset for len %0d", len),
                int'(saw_rst), int'(len >= MC));
            chk(cpu_reset == 1'b0, $sformatf("R1 recovery len %0d", len), int'(cpu_reset), 0);
        end

        // R2/R3: power-down pin length sweep
        for (int len = 1; len <= PD_LEN + 3; len++) begin
            arm();
            pulse_hpd(len);
            wait_neg(len + 40);
            disarm();
            chk(saw_rst == (len >= MC), $sformatf("R2 reset for hpd len %0d", len),
                int'(saw_rst), int'(len >= MC));
            chk(saw_flt == (len >= PD_LEN), $sformatf("R3 float for hpd len %0d", len),
                int'(saw_flt), int'(len >= PD_LEN));
            chk(cpu_reset == 1'b0 && pins_float == 1'b0, $sformatf("R3 wake len %0d", len),
                int'({cpu_reset, pins_float}), 0);
        end

        // R3/R5: state during a held power-down
        @(negedge clk); hpd_pin_n = 1'b0;
        wait_neg(30);
        chk(pins_float == 1'b1, "R3 float while held", int'(pins_float), 1);
        chk(cpu_reset == 1'b1, "R3 reset while floating", int'(cpu_reset), 1);
        chk(reset_out == 1'b0, "R5 reset_out low while floating", int'(reset_out), 0);
        hpd_pin_n = 1'b1;
        wait_neg(4);
        chk(reset_out == 1'b1, "R5 reset_out high after wake", int'(reset_out), 1);
        wait_neg(20);

        // R4: single-cycle watchdog pulses
        arm();
        @(negedge clk); wdt_rst_req = 1'b1;
        @(negedge clk); wdt_rst_req = 1'b0;
        wait_neg(25);
        disarm();
        chk(ro_cnt == MC + 1, "R4 wdt reset length", ro_cnt, MC + 1);
        arm();
        @(negedge clk); owdt_rst_req = 1'b1;
        @(negedge clk); owdt_rst_req = 1'b0;
        wait_neg(25);
        disarm();
        chk(ro_cnt == MC + 1, "R4 osc wdt reset length", ro_cnt, MC + 1);
        chk(cpu_reset == 1'b0, "R4 runs after wdt", int'(cpu_reset), 0);

        // R6/R7: configuration capture via reset pin, pins changed afterwards
        for (int cfg = 0; cfg < 4; cfg++) begin
            prog_pin = cfg[0];
            psen_pin = cfg[1];
            pulse_rst(10);
            wait_neg(30);
            prog_pin = ~cfg[0];
            psen_pin = ~cfg[1];
            wait_neg(10);
            chk(boot_mode == cfg[0], $sformatf("R6 boot cfg %0d", cfg), int'(boot_mode), cfg & 1);
            chk(wdt_autostart == cfg[1], $sformatf("R7 autostart cfg %0d", cfg),
                int'(wdt_autostart), (cfg >> 1) & 1);
        end

        // R6: capture after a power-down wake
        prog_pin = 1'b1;
        pulse_hpd(20);
        wait_neg(40);
        prog_pin = 1'b0;
        wait_neg(5);
        chk(boot_mode == 1'b1, "R6 boot after power-down", int'(boot_mode), 1);

        // R8: power-save request gating sweep
        for (int ps = 0; ps < 2; ps++) begin
            for (int rq = 0; rq < 8; rq++) begin
                @(negedge clk);
                psen_pin = ps[0];
                sw_save_req = rq[2:0];
                wait_neg(4);
                chk(save_grant == (ps != 0 ? 3'b000 : rq[2:0]),
                    $sformatf("R8 grant ps %0d req %0d", ps, rq),
                    int'(save_grant), (ps != 0) ? 0 : rq);
            end
        end
        sw_save_req = 3'b000;
        psen_pin = 1'b1;
        wait_neg(5);

        // R10: watchdog activity during a long power-down low
        arm();
        @(negedge clk); hpd_pin_n = 1'b0;
        for (int i = 0; i < 30; i++) begin
            wdt_rst_req = i[0];
            @(negedge clk);
        end
        hpd_pin_n = 1'b1;
        wdt_rst_req = 1'b0;
        wait_neg(40);
        disarm();
        chk(saw_flt == 1'b1, "R10 float reached with wdt activity", int'(saw_flt), 1);
        chk(cpu_reset == 1'b0 && pins_float == 1'b0, "R10 runs after wake",
            int'({cpu_reset, pins_float}), 0);

        summary_and_end();
    end

endmodule